// File: doc/BRIEF.md
# Processor Address Map Decoder

This block sorts every processor access by its 32-bit address into one of three spaces. The lowest 4 Mbytes hold the on-chip memories. The highest 4 Mbytes hold the on-chip peripherals. Everything in between goes to the external bus, which is split into banks, one per chip select. Each bank has a base and a span that are set through a small configuration write port. An access to external space that lands in no usable bank is flagged as an abort. Accesses to the other two spaces never abort, even at undefined addresses.

The first megabyte of the address space works as a boot window. Out of reset it routes to chip select 0, so the processor can fetch from the boot device. A single write that sets the remap control bit moves internal SRAM onto that window. The remap state is sticky: software cannot undo it, and only a reset clears it. Chip selects 1 and up can be reached only after remap. Peripheral accesses of byte or half-word size are turned into aligned word accesses. The decode itself is combinational; the remap flag and the bank settings are the only state.

Top module: `mem_map_decoder`

## Requirements
- R1: With `acc_valid` high, an address whose bits [31:22] are all zero selects internal space or the boot window. If bits [31:22] are all one, it selects peripheral space. Any other address is external space. At most one of `sel_int`, `sel_ext` and `sel_per` is high.
- R2: Before remap, an address below 0x0010_0000 drives `sel_ext` with `cs_idx` = 0 and does not abort, whatever bank 0 is set to. Addresses from 0x0010_0000 to 0x003F_FFFF drive `sel_int`.
- R3: A cycle with `remap_wr`=1 and `remap_bit`=1 sets remap from the next clock edge. After that, addresses below 0x0010_0000 drive `sel_int`. A write with `remap_bit`=0 leaves the decode unchanged.
- R4: Once set, remap stays set through later writes of any value. Only a low `rst_n` clears it.
- R5: Before remap, banks 1 to 7 never match. An external access inside their range aborts, unless bank 0 matches it.
- R6: A configuration write (`cfg_wr`=1) loads the enable, base and size code of bank `cfg_sel` at the clock edge. The base is compared with address bits [31:20]. The size code k selects a 2^k-Mbyte span (k = 0 to 4; codes 5 to 7 act as 4). The span ignores the low k bits of the base. The lowest-numbered matching bank wins, and its number appears on `cs_idx`.
- R7: `abort` is high only for a valid external access that matches no usable bank. Internal and peripheral accesses never abort.
- R8: A peripheral access forwards `fwd_addr` with bits [1:0] cleared, and `eff_size` = 2 (word) whatever `acc_size` is (0 byte, 1 half-word, 2 word). Other accesses forward the address and size unchanged.
- R9: For a peripheral access, `per_slot` carries address bits [21:14], which number the 16-Kbyte windows. `per_irqc` is high when bits [21:12] are all one, which is the 4-Kbyte interrupt controller window at 0xFFFF_F000.
- R10: While `acc_valid` is low, every decode output is zero.
- R11: After reset, remap is clear and all banks are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| remap_wr | input | 1 | Write strobe for the remap control bit |
| remap_bit | input | 1 | Value written to the remap control bit |
| cfg_wr | input | 1 | Bank configuration write strobe |
| cfg_sel | input | 3 | Bank being configured |
| cfg_en | input | 1 | Bank enable |
| cfg_base | input | 12 | Bank base, address bits [31:20] |
| cfg_size | input | 3 | Bank size code, span 2^k Mbytes |
| sel_int | output | 1 | Internal memory selected |
| sel_ext | output | 1 | External bank selected |
| sel_per | output | 1 | Peripheral space selected |
| cs_idx | output | 3 | Chip select of the external access |
| fwd_addr | output | 32 | Forwarded address (word-aligned for peripherals) |
| eff_size | output | 2 | Effective access size |
| per_slot | output | 8 | Peripheral window number |
| per_irqc | output | 1 | Interrupt controller window hit |
| abort | output | 1 | Undefined external address |

## Verification
The bench builds the block with its defaults: eight chip selects, a 4-Mbyte internal region, a 1-Mbyte boot window and 16-Kbyte peripheral windows. This covers the full gate on chip selects 1 to 7 and all five span sizes, including aliases of the saturating size codes. It also lets overlapping banks on adjacent indices exercise the priority rule. Random bank layouts and mixed addresses reach both boundaries of external space. The directed cases cover the boot-window switch, remap being sticky, and reset clearing remap.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned MB_LOG2   = 20;
  localparam int unsigned BASE_W    = ADDR_W - MB_LOG2;
  localparam int unsigned SZ_W      = 3;
  localparam int unsigned SZ_MAX    = 4;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [SZ_W-1:0]   size;
  } bank_cfg_t;

  // Mask of the base bits that take part in the compare for a size code.
  function automatic logic [BASE_W-1:0] span_mask(input logic [SZ_W-1:0] code);
    int unsigned k;
    k = (int'(code) > SZ_MAX) ? SZ_MAX : int'(code);
    return {BASE_W{1'b1}} << k;
  endfunction
endpackage

// File: rtl/mmd_remap_ctl.sv
module mmd_remap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic remap_wr,
  input  logic remap_bit,
  output logic remap_q
);
  logic remap_d;
  logic remap_ce;

  // Only a set request changes the flag; it never clears from software.
  always_comb begin
    remap_ce = remap_wr && remap_bit && !remap_q;
    remap_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        remap_q <= 1'b0;
    else if (remap_ce) remap_q <= remap_d;
  end

  p_remap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    remap_q |=> remap_q);
  p_remap_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_wr && remap_bit) |=> remap_q);
endmodule

// File: rtl/mmd_bank_table.sv
module mmd_bank_table
  import mmd_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic              cfg_en,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              remap_i,
  input  logic [BASE_W-1:0] lookup,
  output logic [NUM_CS-1:0] hit
);
  bank_cfg_t cfg_new;

  always_comb begin
    cfg_new.en   = cfg_en;
    cfg_new.base = cfg_base;
    cfg_new.size = cfg_size;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
    bank_cfg_t        cfg_q;
    logic             we;
    logic [BASE_W-1:0] msk;
    logic             usable;

    always_comb begin
      we  = cfg_wr && (cfg_sel == CS_W'(i));
      msk = span_mask(cfg_q.size);
      // Chip select 0 is always reachable; the rest wait for remap.
      usable = cfg_q.en && ((i == 0) || remap_i);
      hit[i] = usable && ((lookup & msk) == (cfg_q.base & msk));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= '0;
      else if (we) cfg_q <= cfg_new;
    end
  end
endmodule

// File: rtl/mmd_cs_pick.sv
module mmd_cs_pick #(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] hit,
  output logic              any,
  output logic [CS_W-1:0]   idx
);
  // Scan downward so the lowest matching index is the last assignment.
  always_comb begin
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit[i]) idx = CS_W'(i);
    end
    any = |hit;
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int unsigned NUM_CS       = 8,
  parameter int unsigned INT_LOG2     = 22,
  parameter int unsigned BOOT_LOG2    = 20,
  parameter int unsigned PER_WIN_LOG2 = 14,
  parameter int unsigned IRQC_LOG2    = 12,
  localparam int unsigned CS_W        = $clog2(NUM_CS),
  localparam int unsigned SLOT_W      = INT_LOG2 - PER_WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              remap_wr,
  input  logic              remap_bit,
  input  logic              cfg_wr,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic              cfg_en,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  output logic              sel_int,
  output logic              sel_ext,
  output logic              sel_per,
  output logic [CS_W-1:0]   cs_idx,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [1:0]        eff_size,
  output logic [SLOT_W-1:0] per_slot,
  output logic              per_irqc,
  output logic              abort
);
  localparam logic [1:0] SIZE_WORD = 2'd2;

  // Reset: asserted at once, released through two flops.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic              remap_q;
  logic [NUM_CS-1:0] hit;
  logic              hit_any;
  logic [CS_W-1:0]   hit_idx;

  mmd_remap_ctl u_remap (
    .clk      (clk),
    .rst_n    (rst_s2),
    .remap_wr (remap_wr),
    .remap_bit(remap_bit),
    .remap_q  (remap_q)
  );

  mmd_bank_table #(.NUM_CS(NUM_CS)) u_banks (
    .clk     (clk),
    .rst_n   (rst_s2),
    .cfg_wr  (cfg_wr),
    .cfg_sel (cfg_sel),
    .cfg_en  (cfg_en),
    .cfg_base(cfg_base),
    .cfg_size(cfg_size),
    .remap_i (remap_q),
    .lookup  (acc_addr[ADDR_W-1:MB_LOG2]),
    .hit     (hit)
  );

  mmd_cs_pick #(.NUM_CS(NUM_CS)) u_pick (
    .hit(hit),
    .any(hit_any),
    .idx(hit_idx)
  );

  logic int_sp, per_sp, ext_sp, boot_win;

  always_comb begin
    int_sp   = (acc_addr[ADDR_W-1:INT_LOG2] == '0);
    per_sp   = (acc_addr[ADDR_W-1:INT_LOG2] == '1);
    ext_sp   = !int_sp && !per_sp;
    boot_win = int_sp && (acc_addr[INT_LOG2-1:BOOT_LOG2] == '0);

    sel_int  = 1'b0;
    sel_ext  = 1'b0;
    sel_per  = 1'b0;
    cs_idx   = '0;
    abort    = 1'b0;
    fwd_addr = '0;
    eff_size = '0;
    per_slot = '0;
    per_irqc = 1'b0;

    if (acc_valid) begin
      fwd_addr = acc_addr;
      eff_size = acc_size;
      if (per_sp) begin
        sel_per       = 1'b1;
        fwd_addr[1:0] = 2'b00;
        eff_size      = SIZE_WORD;
        per_slot      = acc_addr[INT_LOG2-1:PER_WIN_LOG2];
        per_irqc      = &acc_addr[INT_LOG2-1:IRQC_LOG2];
      end else if (int_sp) begin
        if (boot_win && !remap_q) sel_ext = 1'b1;
        else                      sel_int = 1'b1;
      end else if (hit_any) begin
        sel_ext = 1'b1;
        cs_idx  = hit_idx;
      end else begin
        abort = 1'b1;
      end
    end
  end

  p_one_space_r1: assert property (@(posedge clk) disable iff (!rst_s2)
    $onehot0({sel_int, sel_ext, sel_per, abort}));
  p_abort_ext_only_r7: assert property (@(posedge clk) disable iff (!rst_s2)
    abort |-> (ext_sp && acc_valid && !hit_any));
  p_cs_gate_r5: assert property (@(posedge clk) disable iff (!rst_s2)
    (sel_ext && !remap_q) |-> (cs_idx == '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s2)
    !acc_valid |-> !(sel_int || sel_ext || sel_per || abort));
endmodule

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  localparam time CYC = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic        remap_wr, remap_bit;
  logic        cfg_wr, cfg_en;
  logic [2:0]  cfg_sel, cfg_size;
  logic [11:0] cfg_base;
  logic        sel_int, sel_ext, sel_per, per_irqc, abort;
  logic [2:0]  cs_idx;
  logic [31:0] fwd_addr;
  logic [1:0]  eff_size;
  logic [7:0]  per_slot;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model of the state.
  logic        m_remap;
  logic        m_en   [8];
  logic [11:0] m_base [8];
  logic [2:0]  m_size [8];

  always #(CYC/2) clk = ~clk;

  mem_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .remap_wr(remap_wr), .remap_bit(remap_bit),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .sel_int(sel_int), .sel_ext(sel_ext), .sel_per(sel_per),
    .cs_idx(cs_idx), .fwd_addr(fwd_addr), .eff_size(eff_size),
    .per_slot(per_slot), .per_irqc(per_irqc), .abort(abort)
  );

  // Packed outputs: int ext per cs[3] addr[32] size[2] slot[8] irqc abort
  function automatic logic [49:0] expect_out(input logic v, input logic [31:0] a,
                                             input logic [1:0] s);
    logic i_, e_, p_, irq, ab;
    logic [2:0] cs;
    logic [31:0] fa;
    logic [1:0] es;
    logic [7:0] sl;
    logic found;
    logic [11:0] msk;
    {i_, e_, p_, irq, ab} = '0;
    cs = '0; fa = '0; es = '0; sl = '0;
    if (v) begin
      fa = a; es = s;
      if (a[31:22] == 10'h3FF) begin
        p_ = 1'b1; fa[1:0] = 2'b00; es = 2'd2;
        sl = a[21:14]; irq = &a[21:12];
      end else if (a[31:22] == 10'h000) begin
        if (a[21:20] == 2'b00 && !m_remap) e_ = 1'b1;
        else i_ = 1'b1;
      end else begin
        found = 1'b0;
        for (int b = 0; b < 8; b++) begin
          msk = 12'hFFF << ((m_size[b] > 3'd4) ? 4 : m_size[b]);
          if (!found && m_en[b] && (b == 0 || m_remap) &&
              ((a[31:20] & msk) == (m_base[b] & msk))) begin
            found = 1'b1; cs = 3'(b);
          end
        end
        if (found) e_ = 1'b1; else ab = 1'b1;
      end
    end
    return {i_, e_, p_, cs, fa, es, sl, irq, ab};
  endfunction

  task automatic check(input string req, input logic [49:0] exp);
    logic [49:0] got;
    got = {sel_int, sel_ext, sel_per, cs_idx, fwd_addr, eff_size, per_slot, per_irqc, abort};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, acc_addr, got, exp);
    end
  endtask

  task automatic probe(input string req, input logic v, input logic [31:0] a,
                       input logic [1:0] s);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = s;
    #1;
    check(req, expect_out(v, a, s));
  endtask

  task automatic cfg(input int b, input logic en, input logic [11:0] base,
                     input logic [2:0] sz);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 3'(b); cfg_en = en; cfg_base = base; cfg_size = sz;
    @(posedge clk);
    m_en[b] = en; m_base[b] = base; m_size[b] = sz;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic remap_write(input logic v);
    @(negedge clk);
    remap_wr = 1'b1; remap_bit = v;
    @(posedge clk);
    if (v) m_remap = 1'b1;
    @(negedge clk);
    remap_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_remap = 1'b0;
    for (int b = 0; b < 8; b++) begin
      m_en[b] = 1'b0; m_base[b] = '0; m_size[b] = '0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CYC * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'h1F2E3D4C));
    acc_valid = 0; acc_addr = '0; acc_size = '0;
    remap_wr = 0; remap_bit = 0;
    cfg_wr = 0; cfg_en = 0; cfg_sel = '0; cfg_base = '0; cfg_size = '0;
    rst_n = 1'b1;
    do_reset();

    // R10 / R11: idle and post-reset state.
    probe("R10", 1'b0, 32'h1234_5678, 2'd1);
    probe("R11", 1'b1, 32'h0500_0000, 2'd2);
    // R1 / R2: boot window before remap, internal above it.
    probe("R2", 1'b1, 32'h0000_0010, 2'd2);
    probe("R2", 1'b1, 32'h000F_FFFC, 2'd0);
    probe("R1", 1'b1, 32'h0010_0000, 2'd2);
    probe("R1", 1'b1, 32'h003F_FFFF, 2'd0);
    probe("R7", 1'b1, 32'h0040_0000, 2'd2);
    probe("R7", 1'b1, 32'hFFBF_FFFF, 2'd2);
    // R8 / R9: peripheral alignment and windows.
    probe("R9", 1'b1, 32'hFFFF_F123, 2'd0);
    probe("R8", 1'b1, 32'hFFC0_4007, 2'd1);
    probe("R9", 1'b1, 32'hFFFF_EFFC, 2'd2);
    // R5: bank 1 set up before remap stays unreachable.
    cfg(1, 1'b1, 12'h010, 3'd4);
    probe("R5", 1'b1, 32'h0123_4560, 2'd2);
    cfg(0, 1'b1, 12'h020, 3'd0);
    probe("R6", 1'b1, 32'h020F_FFF0, 2'd2);
    probe("R6", 1'b1, 32'h0210_0000, 2'd2);
    // R3: a zero write changes nothing, a one write remaps.
    remap_write(1'b0);
    probe("R3", 1'b1, 32'h0000_0100, 2'd2);
    remap_write(1'b1);
    probe("R3", 1'b1, 32'h0000_0100, 2'd2);
    probe("R5", 1'b1, 32'h0123_4560, 2'd2);
    // R6: overlap priority and saturating size code.
    cfg(3, 1'b1, 12'h400, 3'd2);
    cfg(2, 1'b1, 12'h401, 3'd7);
    probe("R6", 1'b1, 32'h4020_0000, 2'd2);
    probe("R6", 1'b1, 32'h40F0_0000, 2'd2);
    probe("R6", 1'b1, 32'h4100_0000, 2'd2);
    // R4: sticky through a zero write, cleared by reset.
    remap_write(1'b0);
    probe("R4", 1'b1, 32'h0000_0040, 2'd2);
    do_reset();
    probe("R4", 1'b1, 32'h0000_0040, 2'd2);
    probe("R11", 1'b1, 32'h4020_0000, 2'd2);

    // Random layouts and addresses.
    for (int r = 0; r < 40; r++) begin
      if (r == 20) remap_write(1'b1);
      for (int b = 0; b < 8; b++)
        cfg(b, 1'($urandom), 12'($urandom_range(4, 4091)), 3'($urandom));
      for (int k = 0; k < 60; k++) begin
        case ($urandom_range(0, 3))
          0: a = {m_base[$urandom_range(0, 7)], 20'($urandom)};
          1: a = {10'h000, 22'($urandom)};
          2: a = {10'h3FF, 22'($urandom)};
          default: a = $urandom;
        endcase
        probe("R6", 1'($urandom_range(0, 7) != 0), a, 2'($urandom_range(0, 2)));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule